// File: doc/BRIEF.md
# Stereo Soft-Stepping PCM Attenuator

This block scales a stereo stream of signed PCM samples. Each channel has its own 8-bit attenuation code. The code selects a gain on a half-decibel ladder that runs from unity down to a full mute. The gain that is actually applied is held in a per-channel level register. That register does not jump to a new code. It moves one ladder position per incoming sample toward the requested code, so a change of setting never produces a step in the output waveform.

A shared soft-mute input sends both level registers toward the mute position by the same one-step-per-sample rule. When soft-mute is released, each register climbs back to its channel's code.

Beside the gain path, each channel has a zero-run watcher. The watcher raises a flag once the channel has delivered a long unbroken run of all-zero input samples. A single detector enable gates both flags. Samples enter on a valid strobe. The scaled result appears one clock later with its own valid strobe.

Top module: `pcm_step_atten`

## Requirements
- R1: While `rst_n` is low and until the first output strobe, `out_vld`, `out_l`, `out_r`, `zflag_l` and `zflag_r` are 0. Both applied levels reset to code 0 (mute), so the first accepted sample on each channel produces a 0 output.
- R2: The gain coefficient has 24 fractional bits. Code 255 gives exactly 2^24, which is unity. For 1 <= k <= 254 the coefficient is c(k) = floor((c(k+1) * 4054710588 + 2^31) / 2^32), where 4054710588/2^32 is -0.5 dB. Code 0 gives 0. Code 243 therefore lies within 0.1 % of 2^24 * 10^(-0.3).
- R3: On each clock with `in_vld` high, the applied level of a channel moves by exactly one code toward its target, or stays put if it already equals the target. Without `in_vld` the level does not change. A sample is scaled with the level that was held before its own strobe.
- R4: One clock after a strobe, `out_vld` pulses high for one clock. Each output equals the input times c(level), plus 2^23, arithmetically shifted right by 24 and saturated to the signed sample range. The output register holds its value between strobes.
- R5: While `smute` is high, the target of both channels is code 0. After `smute` falls, each target returns to that channel's attenuation code.
- R6: The left and right channels have independent codes, levels and outputs. A code on one channel has no effect on the other channel's output.
- R7: A zero flag rises on the clock after the ZERO_RUN-th consecutive strobe whose sample on that channel is 0. It stays low through the first ZERO_RUN-1 such strobes. ZERO_RUN defaults to 8192.
- R8: A strobe that carries a non-zero sample on a channel drives that channel's zero flag low on the next clock and restarts its run count.
- R9: While `zdet_en` is 0 both zero flags are 0. Run counting continues meanwhile, so a run that is already complete shows its flag as soon as `zdet_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Sample strobe for both channels |
| in_l | input | DATA_W | Left sample, signed |
| in_r | input | DATA_W | Right sample, signed |
| att_l | input | 8 | Left attenuation code (255 = 0 dB, 0 = mute) |
| att_r | input | 8 | Right attenuation code |
| smute | input | 1 | Soft-mute request for both channels |
| zdet_en | input | 1 | Zero-flag enable |
| out_vld | output | 1 | Output strobe, one clock after in_vld |
| out_l | output | DATA_W | Scaled left sample, signed |
| out_r | output | DATA_W | Scaled right sample, signed |
| zflag_l | output | 1 | Left zero-run flag |
| zflag_r | output | 1 | Right zero-run flag |

## Verification
The hardest situation to reach from the ports is the one where every one of the 256 coefficients is actually applied. The applied level can only be steered one code per strobe, so codes cannot be visited directly. The stimulus therefore starts from the muted reset level and sends a long train of full-scale positive samples on one channel and full-scale negative samples on the other. That train walks the level through every code with both signs. Afterwards the bench drives soft-mute descents and returns, a split-code phase, small-magnitude rounding sweeps, and a zero run of exactly the threshold length with the enable toggled around it.

// File: rtl/pcm_step_atten_pkg.sv
package pcm_step_atten_pkg;

  localparam int LVL_W    = 8;
  localparam int N_LVL    = 1 << LVL_W;
  localparam int FRAC     = 24;
  localparam int COEF_W   = FRAC + 1;
  localparam logic [63:0] STEP_MUL = 64'd4054710588;   // -0.5 dB in Q0.32

  typedef logic [LVL_W-1:0]  lvl_t;
  typedef logic [COEF_W-1:0] coef_t;

  // Gain ladder: top entry is unity, each lower entry is 0.5 dB below, entry 0 is zero.
  function automatic logic [N_LVL*COEF_W-1:0] build_coefs();
    logic [63:0] acc;
    build_coefs = '0;
    acc = 64'd1 << FRAC;
    build_coefs[(N_LVL-1)*COEF_W +: COEF_W] = COEF_W'(acc);
    for (int k = N_LVL - 2; k >= 1; k--) begin
      acc = (acc * STEP_MUL + (64'd1 << 31)) >> 32;
      build_coefs[k*COEF_W +: COEF_W] = COEF_W'(acc);
    end
  endfunction

  localparam logic [N_LVL*COEF_W-1:0] COEF_TAB = build_coefs();

  function automatic coef_t coef_of(lvl_t lvl);
    return COEF_TAB[lvl*COEF_W +: COEF_W];
  endfunction

  function automatic lvl_t step_toward(lvl_t cur, lvl_t tgt);
    if (cur < tgt)      return cur + LVL_W'(1);
    else if (cur > tgt) return cur - LVL_W'(1);
    else                return cur;
  endfunction

endpackage

// File: rtl/att_level_ctl.sv
module att_level_ctl
  import pcm_step_atten_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_vld,
  input  lvl_t code,
  input  logic smute,
  output lvl_t lvl
);

  lvl_t tgt;
  logic step_evt;

  assign tgt      = smute ? '0 : code;
  assign step_evt = in_vld;

  always_ff @(posedge clk) begin
    if (!rst_n)        lvl <= '0;
    else if (step_evt) lvl <= step_toward(lvl, tgt);
  end

  // R3: never more than one code per strobe
  p_one_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (lvl == $past(lvl)) ||
                 ({1'b0, lvl} == {1'b0, $past(lvl)} + 9'd1) ||
                 ({1'b0, lvl} + 9'd1 == {1'b0, $past(lvl)}));

  // R3: level frozen between strobes
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !step_evt |=> $stable(lvl));

  // R5: soft mute pulls the level down each strobe
  p_mute_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && smute && lvl != '0) |=> (lvl == $past(lvl) - LVL_W'(1)));

endmodule

// File: rtl/att_scale.sv
module att_scale
  import pcm_step_atten_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_vld,
  input  logic signed [DATA_W-1:0] x,
  input  lvl_t                     lvl,
  output logic signed [DATA_W-1:0] y
);

  localparam int PW = DATA_W + COEF_W + 1;
  localparam logic signed [PW-1:0] HALF = PW'(64'd1 << (FRAC - 1));
  localparam logic signed [PW-1:0] HI   = PW'((64'd1 << (DATA_W - 1)) - 64'd1);
  localparam logic signed [PW-1:0] LO   = -HI - PW'(1);

  function automatic logic signed [DATA_W-1:0] scale_round(logic signed [DATA_W-1:0] s, coef_t c);
    logic signed [PW-1:0] se, ce, prod, shr;
    se   = PW'(s);
    ce   = $signed({{(DATA_W+1){1'b0}}, c});
    prod = se * ce;
    shr  = (prod + HALF) >>> FRAC;
    if (shr > HI)      return HI[DATA_W-1:0];
    else if (shr < LO) return LO[DATA_W-1:0];
    else               return shr[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W:0] mag(logic signed [DATA_W-1:0] v);
    logic signed [DATA_W:0] e;
    e = DATA_W'(1) == 0 ? '0 : {v[DATA_W-1], v};
    return (e < 0) ? -e : e;
  endfunction

  coef_t                     coef;
  logic signed [DATA_W-1:0]  y_nxt;

  assign coef  = coef_of(lvl);
  assign y_nxt = scale_round(x, coef);

  always_ff @(posedge clk) begin
    if (!rst_n)      y <= '0;
    else if (in_vld) y <= y_nxt;
  end

  // R4: attenuation never grows the magnitude
  p_no_growth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (mag(y) <= mag($past(x))));

endmodule

// File: rtl/zero_watch.sv
module zero_watch #(
  parameter int DATA_W   = 24,
  parameter int ZERO_RUN = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] sample,
  input  logic              en,
  output logic              flag
);

  localparam int CNT_W = $clog2(ZERO_RUN + 1);

  logic [CNT_W-1:0] cnt;
  logic             run_done;
  logic             is_zero;

  assign is_zero  = (sample == '0);
  assign run_done = (cnt == CNT_W'(ZERO_RUN));
  assign flag     = en & run_done;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (in_vld) begin
      if (!is_zero)         cnt <= '0;
      else if (!run_done)   cnt <= cnt + CNT_W'(1);
    end
  end

  // R8: a non-zero sample clears the flag on the next clock
  p_flag_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !is_zero) |=> !flag);

  // R7: a run completes only on a zero-sample strobe
  p_run_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_done) |-> ($past(in_vld) && $past(is_zero)));

endmodule

// File: rtl/pcm_step_atten.sv
module pcm_step_atten
  import pcm_step_atten_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int ZERO_RUN = 8192
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_vld,
  input  logic signed [DATA_W-1:0] in_l,
  input  logic signed [DATA_W-1:0] in_r,
  input  logic [LVL_W-1:0]         att_l,
  input  logic [LVL_W-1:0]         att_r,
  input  logic                     smute,
  input  logic                     zdet_en,
  output logic                     out_vld,
  output logic signed [DATA_W-1:0] out_l,
  output logic signed [DATA_W-1:0] out_r,
  output logic                     zflag_l,
  output logic                     zflag_r
);

  localparam int N_CH = 2;

  logic signed [DATA_W-1:0] ch_in  [N_CH];
  logic signed [DATA_W-1:0] ch_out [N_CH];
  lvl_t                     ch_code[N_CH];
  lvl_t                     ch_lvl [N_CH];
  logic                     ch_flag[N_CH];

  assign ch_in[0]   = in_l;
  assign ch_in[1]   = in_r;
  assign ch_code[0] = att_l;
  assign ch_code[1] = att_r;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    att_level_ctl u_lvl (
      .clk   (clk),
      .rst_n (rst_n),
      .in_vld(in_vld),
      .code  (ch_code[c]),
      .smute (smute),
      .lvl   (ch_lvl[c])
    );

    att_scale #(.DATA_W(DATA_W)) u_scale (
      .clk   (clk),
      .rst_n (rst_n),
      .in_vld(in_vld),
      .x     (ch_in[c]),
      .lvl   (ch_lvl[c]),
      .y     (ch_out[c])
    );

    zero_watch #(.DATA_W(DATA_W), .ZERO_RUN(ZERO_RUN)) u_zero (
      .clk   (clk),
      .rst_n (rst_n),
      .in_vld(in_vld),
      .sample(ch_in[c]),
      .en    (zdet_en),
      .flag  (ch_flag[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= in_vld;
  end

  assign out_l   = ch_out[0];
  assign out_r   = ch_out[1];
  assign zflag_l = ch_flag[0];
  assign zflag_r = ch_flag[1];

  // R4: output strobe follows the input strobe by one clock
  p_strobe_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

endmodule

// File: tb/pcm_step_atten_tb_top.sv
module pcm_step_atten_tb_top;

  localparam int DW = 24;
  localparam int ZR = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic signed [DW-1:0] in_l = '0, in_r = '0;
  logic [7:0] att_l = 8'd255, att_r = 8'd255;
  logic smute = 1'b0, zdet_en = 1'b1;
  logic out_vld;
  logic signed [DW-1:0] out_l, out_r;
  logic zflag_l, zflag_r;

  always #2.5 clk = ~clk;   // 200 MHz

  pcm_step_atten #(.DATA_W(DW), .ZERO_RUN(ZR)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_l(in_l), .in_r(in_r),
    .att_l(att_l), .att_r(att_r), .smute(smute), .zdet_en(zdet_en),
    .out_vld(out_vld), .out_l(out_l), .out_r(out_r),
    .zflag_l(zflag_l), .zflag_r(zflag_r)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  longint coef [256];
  int lvl_m [2];
  int zrun_m [2];

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint expect_out(longint x, int lvl);
    longint p, r;
    longint hi = (longint'(1) <<< (DW - 1)) - 1;
    p = x * coef[lvl];
    r = (p + (longint'(1) <<< 23)) >>> 24;
    if (r > hi) r = hi;
    if (r < -hi - 1) r = -hi - 1;
    return r;
  endfunction

  function automatic int target_of(int ch);
    if (smute) return 0;
    return (ch == 0) ? int'(att_l) : int'(att_r);
  endfunction

  // One strobe; checks outputs, strobe and flags against the model (R3 R4 R7 R8 R9)
  task automatic send(longint xl, longint xr);
    longint el, er;
    @(negedge clk);
    in_vld = 1'b1;
    in_l = DW'(xl);
    in_r = DW'(xr);
    el = expect_out(xl, lvl_m[0]);
    er = expect_out(xr, lvl_m[1]);
    for (int c = 0; c < 2; c++) begin
      int t = target_of(c);
      if (lvl_m[c] < t) lvl_m[c]++;
      else if (lvl_m[c] > t) lvl_m[c]--;
    end
    zrun_m[0] = (xl != 0) ? 0 : ((zrun_m[0] < ZR) ? zrun_m[0] + 1 : ZR);
    zrun_m[1] = (xr != 0) ? 0 : ((zrun_m[1] < ZR) ? zrun_m[1] + 1 : ZR);
    @(negedge clk);
    in_vld = 1'b0;
    chk("R4 out_vld pulse", longint'(out_vld), 1);
    chk("R4 R3 left value", longint'(out_l), el);
    chk("R4 R3 right value", longint'(out_r), er);
    chk("R7 R8 left flag", longint'(zflag_l), longint'(zdet_en && zrun_m[0] == ZR));
    chk("R7 R8 right flag", longint'(zflag_r), longint'(zdet_en && zrun_m[1] == ZR));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    longint sl, sr, hold_l;
    real ideal;
    coef[255] = longint'(1) <<< 24;
    for (int k = 254; k >= 1; k--)
      coef[k] = (coef[k+1] * 64'd4054710588 + (longint'(1) <<< 31)) >>> 32;
    coef[0] = 0;
    lvl_m[0] = 0; lvl_m[1] = 0; zrun_m[0] = 0; zrun_m[1] = 0;

    // R2: ladder sanity against the ideal -6 dB point
    ideal = 16777216.0 * (10.0 ** (-0.3));
    checks++;
    if ((real'(coef[243]) - ideal) > ideal / 1000.0 || (ideal - real'(coef[243])) > ideal / 1000.0) begin
      errors++;
      $display("FAIL R2 ladder actual=%0d expected=%0d", coef[243], longint'(ideal));
    end

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 out_vld", longint'(out_vld), 0);
    chk("R1 out_l", longint'(out_l), 0);
    chk("R1 out_r", longint'(out_r), 0);
    chk("R1 zflag_l", longint'(zflag_l), 0);
    chk("R1 zflag_r", longint'(zflag_r), 0);
    @(negedge clk) rst_n = 1'b1;

    // R1 R2 R3: climb from mute through every code, both signs at full scale
    sl = (longint'(1) <<< (DW - 1)) - 1;
    sr = -(longint'(1) <<< (DW - 1));
    for (int i = 0; i < 257; i++) begin
      send(sl, sr);
      if (i == 0) begin
        chk("R1 first left at mute", longint'(out_l), 0);
        chk("R1 first right at mute", longint'(out_r), 0);
      end
    end
    chk("R2 unity left", longint'(out_l), sl);
    chk("R2 unity right", longint'(out_r), sr);

    // R4: output held and no strobe while idle
    hold_l = longint'(out_l);
    repeat (5) @(negedge clk);
    chk("R4 idle out_vld", longint'(out_vld), 0);
    chk("R4 idle hold", longint'(out_l), hold_l);

    // R6: split codes, varied samples; right stays at unity
    att_l = 8'd120;
    for (int i = 0; i < 150; i++) begin
      sl = longint'($signed(DW'(i * 104729 + 3)));
      sr = longint'($signed(DW'(i * 7919 - 500000)));
      send(sl, sr);
      chk("R6 right untouched", longint'(out_r), sr);
    end

    // R4: rounding sweep at small magnitudes on several levels
    att_l = 8'd200; att_r = 8'd180;
    for (int i = -40; i <= 40; i++) send(longint'(i) * 37, longint'(-i) * 1001);

    // R5: soft mute to silence and back
    smute = 1'b1;
    for (int i = 0; i < 256; i++) send(1000000, -1000000);
    chk("R5 muted left", longint'(out_l), 0);
    chk("R5 muted right", longint'(out_r), 0);
    smute = 1'b0;
    att_l = 8'd255; att_r = 8'd243;
    for (int i = 0; i < 256; i++) send(1000000, -1000000);
    chk("R5 restored left", longint'(out_l), 1000000);
    chk("R5 restored right", longint'(out_r), expect_out(-1000000, 243));

    // R7: left zero run of exact threshold length, right kept busy
    for (int i = 0; i < ZR - 1; i++) send(0, 5);
    chk("R7 left below run", longint'(zflag_l), 0);
    send(0, 5);
    chk("R7 left at run", longint'(zflag_l), 1);
    chk("R6 right flag independent", longint'(zflag_r), 0);

    // R9: enable gates the flag, counting is kept
    @(negedge clk) zdet_en = 1'b0;
    #1;
    chk("R9 gated left", longint'(zflag_l), 0);
    send(0, 5);
    chk("R9 gated after strobe", longint'(zflag_l), 0);
    @(negedge clk) zdet_en = 1'b1;
    #1;
    chk("R9 re-enabled left", longint'(zflag_l), 1);

    // R8: one non-zero sample drops the flag and restarts the run
    send(1, 5);
    chk("R8 left dropped", longint'(zflag_l), 0);
    send(0, 5);
    chk("R8 run restarted", longint'(zflag_l), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule